// File: doc/BRIEF.md
# Strobe Delay Tap Calibrator

This block searches for the range of read-strobe delay tap settings over which a memory pattern test passes, then settles on the centre of that range. A sweep begins at a supplied starting tap. It first climbs upward one tap at a time, then goes back to the starting point and descends. Before each test, the candidate setting is placed on both tap outputs. An external tester is then asked to check the memory through a one-cycle start pulse, and it answers with a done pulse that carries a pass/fail bit. Each candidate must pass two consecutive test runs to count as passing.

The first failure while climbing fixes the upper edge of the window. The first failure while descending fixes the lower edge and ends the sweep. The tap limits, 0x20 at the top and 0 at the bottom, also close the window. When the sweep ends, tap output 0 receives the truncated midpoint of the two edges and tap output 1 receives that midpoint plus one. A done flag then rises.

The block also contains a combinational generator for the test pattern. It maps a word index to the data word that an external writer places in memory before calibration.

Top module: `tapCalibrator`

## Requirements
- R1: After reset, calDone and testStart are 0, and tap0 and tap1 are both 0.
- R2: A startCal pulse while idle or done loads the starting tap, clamped to 0x20. The first test is on that tap. Whenever testStart is high, tap0 equals tap1, and both hold the candidate under test.
- R3: While climbing, a passing candidate below 0x20 is followed by the next higher tap. A pass at 0x20 sets the upper edge to 0x20, and the next candidate is the starting tap, now descending.
- R4: While climbing, a failing candidate sets the upper edge to the candidate minus one, never below 0. The next candidate is the starting tap, now descending.
- R5: While descending, a failing candidate sets the lower edge to the candidate plus one, capped at 0x20, and ends the sweep. A pass at tap 0 sets the lower edge to 0 and ends the sweep. Any other pass is followed by the next lower tap.
- R6: Each candidate gets a second test run only if the first one passes. A fail on either run makes the candidate fail, so a passing candidate takes two testStart pulses and a failing one takes one or two.
- R7: At the end of a sweep, tap0 = floor((upper+lower)/2) and tap1 = tap0+1. calDone rises in the same cycle these values appear. It holds, and the taps stay stable, until the next startCal.
- R8: patWord for index i is built as follows. The group is g = i[9:2] and the word lane is w = i[1:0]. Bits [15:0] are 0xFFFF when bit 2w of g is set, and 0 otherwise. Bits [31:16] are 0xFFFF when bit 2w+1 of g is set, and 0 otherwise.
- R9: testStart is a single-cycle pulse. No further pulse comes until a testDone has been received for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCal | input | 1 | Pulse that begins a sweep |
| startTap | input | 6 | Starting tap value |
| testStart | output | 1 | Pulse requesting one pattern test run |
| testDone | input | 1 | Pulse ending a test run |
| testPass | input | 1 | Result of the run, valid with testDone |
| tap0 | output | 6 | Tap output 0 |
| tap1 | output | 6 | Tap output 1 |
| calDone | output | 1 | Sweep finished, final taps valid |
| patIndex | input | 10 | Pattern word index |
| patWord | output | 32 | Pattern word for patIndex |

## Verification
The main function is tried against pass windows placed at several positions relative to the starting tap:
- A window strictly inside the range separates the two fail-driven edge rules.
- A window covering the full range exercises the limit at 0x20 and the stop at tap 0.
- A start above 0x20 exercises the clamp.
- A start at 0 that fails exercises the floor on the upper edge.
- A start at 0x20 that fails exercises the cap on the lower edge.

A flaky tap that fails only on its second run shows whether both runs are honoured. Random windows, starting taps and responder delays are compared with a model of the sweep, and random pattern indices with a model of the encoding.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;
  typedef struct packed {
    logic loadStart;
    logic stepUp;
    logic stepDown;
    logic restart;
    logic capUpperFail;
    logic capUpperCur;
    logic capLowerFail;
    logic capLowerCur;
    logic writeFinal;
  } calStrobes_t;
endpackage

// File: rtl/tapDatapath.sv
module tapDatapath
  import tapcal_pkg::*;
#(
  parameter int TAP_W   = 6,
  parameter int TAP_MAX = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobes_t      strobes,
  input  logic [TAP_W-1:0] startTap,
  output logic             atMax,
  output logic             atZero,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1
);
  localparam logic [TAP_W-1:0] MAX_V = TAP_W'(TAP_MAX);

  logic [TAP_W-1:0] curTap, anchorTap, upperEdge, lowerEdge;
  logic [TAP_W-1:0] clampedStart, nextTap, midVal;
  logic [TAP_W:0]   edgeSum;
  logic             tapWrite;

  assign clampedStart = (startTap > MAX_V) ? MAX_V : startTap;
  assign atMax  = (curTap == MAX_V);
  assign atZero = (curTap == '0);
  assign edgeSum = {1'b0, upperEdge} + {1'b0, lowerEdge};
  assign midVal  = edgeSum[TAP_W:1];

  always_comb begin
    nextTap  = curTap;
    tapWrite = 1'b1;
    if (strobes.stepUp)        nextTap = curTap + 1'b1;
    else if (strobes.stepDown) nextTap = curTap - 1'b1;
    else if (strobes.restart)  nextTap = anchorTap;
    else                       tapWrite = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTap    <= '0;
      anchorTap <= '0;
      upperEdge <= '0;
      lowerEdge <= '0;
      tap0      <= '0;
      tap1      <= '0;
    end else if (strobes.loadStart) begin
      curTap    <= clampedStart;
      anchorTap <= clampedStart;
      upperEdge <= clampedStart;
      lowerEdge <= clampedStart;
      tap0      <= clampedStart;
      tap1      <= clampedStart;
    end else begin
      if (tapWrite) begin
        curTap <= nextTap;
        tap0   <= nextTap;
        tap1   <= nextTap;
      end
      if (strobes.capUpperFail) upperEdge <= atZero ? '0 : curTap - 1'b1;
      if (strobes.capUpperCur)  upperEdge <= curTap;
      if (strobes.capLowerFail) lowerEdge <= (curTap >= MAX_V) ? MAX_V : curTap + 1'b1;
      if (strobes.capLowerCur)  lowerEdge <= curTap;
      if (strobes.writeFinal) begin
        tap0 <= midVal;
        tap1 <= midVal + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tapControl.sv
module tapControl
  import tapcal_pkg::*;
#(
  parameter int PASS_RUNS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCal,
  input  logic        testDone,
  input  logic        testPass,
  input  logic        atMax,
  input  logic        atZero,
  output calStrobes_t strobes,
  output logic        testStart,
  output logic        calDone
);
  localparam int RUN_W = $clog2(PASS_RUNS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINAL, S_DONE} calState_t;
  calState_t state, stateNext;
  logic             dirUp;
  logic [RUN_W-1:0] runCnt;
  logic             runAgain, decide, turnDown;

  assign testStart = (state == S_ISSUE);
  assign calDone   = (state == S_DONE);
  assign runAgain  = (state == S_WAIT) && testDone && testPass &&
                     (runCnt < RUN_W'(PASS_RUNS - 1));
  assign decide    = (state == S_WAIT) && testDone && !runAgain;
  assign turnDown  = decide && dirUp && (!testPass || atMax);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      S_IDLE, S_DONE: if (startCal) begin
        strobes.loadStart = 1'b1;
        stateNext = S_ISSUE;
      end
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT: begin
        if (runAgain) stateNext = S_ISSUE;
        else if (decide) begin
          stateNext = S_ISSUE;
          if (dirUp) begin
            if (!testPass) begin
              strobes.capUpperFail = 1'b1;
              strobes.restart      = 1'b1;
            end else if (!atMax) begin
              strobes.stepUp = 1'b1;
            end else begin
              strobes.capUpperCur = 1'b1;
              strobes.restart     = 1'b1;
            end
          end else begin
            if (!testPass) begin
              strobes.capLowerFail = 1'b1;
              stateNext = S_FINAL;
            end else if (atZero) begin
              strobes.capLowerCur = 1'b1;
              stateNext = S_FINAL;
            end else begin
              strobes.stepDown = 1'b1;
            end
          end
        end
      end
      S_FINAL: begin
        strobes.writeFinal = 1'b1;
        stateNext = S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      dirUp  <= 1'b1;
      runCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.loadStart) dirUp <= 1'b1;
      else if (turnDown)     dirUp <= 1'b0;
      if (strobes.loadStart || decide) runCnt <= '0;
      else if (runAgain)               runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/patternWordGen.sv
module patternWordGen #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 32
) (
  input  logic [IDX_W-1:0]  patIndex,
  output logic [WORD_W-1:0] patWord
);
  localparam int HALF_W = WORD_W / 2;
  localparam int GRP_W  = IDX_W - 2;

  logic [GRP_W-1:0] grp;
  logic [1:0]       lane;
  logic             lowSel, highSel;

  assign grp     = patIndex[IDX_W-1:2];
  assign lane    = patIndex[1:0];
  assign lowSel  = grp[{lane, 1'b0}];
  assign highSel = grp[{lane, 1'b1}];
  assign patWord = {{HALF_W{highSel}}, {HALF_W{lowSel}}};
endmodule

// File: rtl/tapCalibrator.sv
module tapCalibrator
  import tapcal_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int TAP_MAX    = 32,
  parameter int PASS_RUNS  = 2,
  parameter int PAT_IDX_W  = 10,
  parameter int PAT_WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startCal,
  input  logic [TAP_W-1:0]      startTap,
  output logic                  testStart,
  input  logic                  testDone,
  input  logic                  testPass,
  output logic [TAP_W-1:0]      tap0,
  output logic [TAP_W-1:0]      tap1,
  output logic                  calDone,
  input  logic [PAT_IDX_W-1:0]  patIndex,
  output logic [PAT_WORD_W-1:0] patWord
);
  calStrobes_t strobes;
  logic        atMax, atZero;

  tapControl #(.PASS_RUNS(PASS_RUNS)) i_ctrl (
    .clk(clk), .rstN(rstN), .startCal(startCal), .testDone(testDone),
    .testPass(testPass), .atMax(atMax), .atZero(atZero),
    .strobes(strobes), .testStart(testStart), .calDone(calDone)
  );

  tapDatapath #(.TAP_W(TAP_W), .TAP_MAX(TAP_MAX)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startTap(startTap),
    .atMax(atMax), .atZero(atZero), .tap0(tap0), .tap1(tap1)
  );

  patternWordGen #(.IDX_W(PAT_IDX_W), .WORD_W(PAT_WORD_W)) i_pat (
    .patIndex(patIndex), .patWord(patWord)
  );
endmodule

// File: rtl/tapCalibratorChecker.sv
module tapCalibratorChecker #(
  parameter int TAP_W      = 6,
  parameter int TAP_MAX    = 32,
  parameter int PAT_WORD_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startCal,
  input logic                  testStart,
  input logic                  testDone,
  input logic [TAP_W-1:0]      tap0,
  input logic [TAP_W-1:0]      tap1,
  input logic                  calDone,
  input logic [PAT_WORD_W-1:0] patWord
);
  localparam int HALF_W = PAT_WORD_W / 2;
  logic waitingDone;

  always_ff @(posedge clk) begin
    if (!rstN) waitingDone <= 1'b0;
    else if (testStart) waitingDone <= 1'b1;
    else if (testDone) waitingDone <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (waitingDone && !testDone) |-> !testStart); // R9
  AST_TAPS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    testStart |-> (tap0 == tap1)); // R2
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    testStart |-> (tap0 <= TAP_W'(TAP_MAX))); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !startCal) |=> (calDone && $stable(tap0) && $stable(tap1))); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    calDone |-> !testStart); // R7
  AST_FINAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> (tap1 == tap0 + 1'b1)); // R7
  AST_PAT_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    ((patWord[HALF_W-1:0] == '0) || (&patWord[HALF_W-1:0])) &&
    ((patWord[PAT_WORD_W-1:HALF_W] == '0) || (&patWord[PAT_WORD_W-1:HALF_W]))); // R8
endmodule

bind tapCalibrator tapCalibratorChecker #(
  .TAP_W(TAP_W), .TAP_MAX(TAP_MAX), .PAT_WORD_W(PAT_WORD_W)
) i_checker (
  .clk(clk), .rstN(rstN), .startCal(startCal), .testStart(testStart),
  .testDone(testDone), .tap0(tap0), .tap1(tap1), .calDone(calDone),
  .patWord(patWord)
);

// File: tb/test_tapCalibrator.sv
module test_tapCalibrator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startCal = 1'b0;
  logic [5:0]  startTap = '0;
  logic        testStart;
  logic        testDone = 1'b0;
  logic        testPass = 1'b0;
  logic [5:0]  tap0, tap1;
  logic        calDone;
  logic [9:0]  patIndex = '0;
  logic [31:0] patWord;

  int errors = 0;
  int checks = 0;
  int winLo = 0, winHi = 0, flakyTap = 99;
  int testCount = 0, mismatchCount = 0;
  int lastTap = -1, attemptCnt = 0;
  bit lastOk = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tapCalibrator i_tapCalibrator (
    .clk(clk), .rstN(rstN), .startCal(startCal), .startTap(startTap),
    .testStart(testStart), .testDone(testDone), .testPass(testPass),
    .tap0(tap0), .tap1(tap1), .calDone(calDone),
    .patIndex(patIndex), .patWord(patWord)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void sweepModel(input int st, input int lo, input int hi,
                                     input int fl, output int upE, output int lwE,
                                     output int nTests);
    int s, v;
    bit up, done, ok;
    s = (st > 32) ? 32 : st;
    v = s; up = 1; done = 0; nTests = 0; upE = s; lwE = s;
    while (!done) begin
      if (v >= lo && v <= hi) begin nTests += 2; ok = (v != fl); end
      else begin nTests += 1; ok = 0; end
      if (up) begin
        if (!ok) begin upE = (v == 0) ? 0 : v - 1; v = s; up = 0; end
        else if (v < 32) v++;
        else begin upE = v; v = s; up = 0; end
      end else begin
        if (!ok) begin lwE = (v >= 32) ? 32 : v + 1; done = 1; end
        else if (v == 0) begin lwE = 0; done = 1; end
        else v--;
      end
    end
  endfunction

  function automatic int patModel(input int idx);
    int g, w, r;
    g = idx >> 2; w = idx & 3; r = 0;
    if ((g >> (2*w)) & 1) r |= 32'h0000FFFF;
    if ((g >> (2*w+1)) & 1) r |= 32'hFFFF0000;
    return r;
  endfunction

  // Tester model: answers each testStart after a random delay
  initial begin
    forever begin
      @(negedge clk);
      testDone = 1'b0;
      if (testStart) begin
        int t, attempt;
        bit ok;
        t = int'(tap0);
        testCount++;
        if (tap0 != tap1) mismatchCount++;
        attempt = (t == lastTap && attemptCnt == 1 && lastOk) ? 2 : 1;
        ok = (t >= winLo && t <= winHi && !(t == flakyTap && attempt == 2));
        lastTap = t; attemptCnt = attempt; lastOk = ok;
        repeat (1 + ($urandom % 4)) @(negedge clk);
        testPass = ok;
        testDone = 1'b1;
      end
    end
  end

  task automatic runScenario(input int st, input int lo, input int hi, input int fl,
                             input string tag);
    int upE, lwE, nT, mid, guard;
    winLo = lo; winHi = hi; flakyTap = fl;
    testCount = 0; mismatchCount = 0; lastTap = -1; attemptCnt = 0;
    sweepModel(st, lo, hi, fl, upE, lwE, nT);
    mid = (upE + lwE) / 2;
    @(negedge clk);
    startTap = 6'(st);
    startCal = 1'b1;
    @(negedge clk);
    startCal = 1'b0;
    guard = 0;
    while (!calDone && guard < 5000) begin @(negedge clk); guard++; end
    check({tag, " R7 calDone"}, int'(calDone), 1);
    check({tag, " R7 tap0 midpoint"}, int'(tap0), mid);
    check({tag, " R7 tap1 midpoint+1"}, int'(tap1), mid + 1);
    check({tag, " R6 test run count"}, testCount, nT);
    check({tag, " R2 tap outputs equal"}, mismatchCount, 0);
    repeat (3) @(negedge clk);
    check({tag, " R7 hold"}, int'(tap0), mid);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 calDone reset", int'(calDone), 0);
    check("R1 testStart reset", int'(testStart), 0);
    check("R1 tap0 reset", int'(tap0), 0);
    check("R1 tap1 reset", int'(tap1), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle no test", int'(testStart), 0);

    runScenario(8, 3, 20, 99, "R4 R5 inner window");
    runScenario(8, 0, 40, 99, "R3 R5 full range");
    runScenario(45, 10, 63, 99, "R2 R3 clamp start");
    runScenario(0, 5, 10, 99, "R4 floor at zero");
    runScenario(8, 0, 30, 12, "R6 flaky second run");
    runScenario(32, 40, 50, 99, "R5 cap at top");
    runScenario(20, 20, 20, 20, "R6 flaky start");
    for (int k = 0; k < 8; k++) begin
      int lo, st;
      lo = $urandom % 34;
      st = $urandom % 64;
      runScenario(st, lo, lo + ($urandom % 20), ($urandom % 2) ? ($urandom % 40) : 99,
                  "R3 R4 R5 random");
    end

    foreach (patIndex[b]) begin end
    for (int k = 0; k < 48; k++) begin
      int idx;
      case (k)
        0: idx = 0;
        1: idx = 1023;
        2: idx = 4 * 8'h55;
        3: idx = 4 * 8'hAA + 3;
        4: idx = 4 * 8'h80 + 3;
        5: idx = 4 * 8'h01;
        default: idx = $urandom % 1024;
      endcase
      @(negedge clk);
      patIndex = 10'(idx);
      #1;
      check("R8 pattern word", int'(patWord), patModel(idx));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule